// File: doc/BRIEF.md
# Machine/User Privilege CSR Controller

This block keeps the privilege level of a hart that has only machine and user modes, and it serves the control and status registers that belong to privilege handling. A trap strobe forces machine mode and saves the prior mode. A return strobe restores the mode saved in the previous-privilege field of the status register. While a trap is signalled, the block also works out the cause code, so that an environment call reports a code that depends on the mode it was made from.

CSR accesses arrive on a valid/ready request channel and produce one registered response per accepted request. The block accepts a request on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is waiting, or when the waiting response is taken in the same cycle. A response stays valid, with a stable payload, until `rsp_ready` is seen high. The CSRs served are the ISA descriptor, the reduced status register, counter enable, environment configuration (low and high halves), security configuration (low and high halves) and the four user counter shadows. The shadows mirror external cycle and retired-instruction counts.

Top module: `priv_csr_ctrl`

## Requirements
- R1: After reset the mode is machine (`priv_mode` = 2'b11), the previous-privilege field reads 2'b11, counter enable reads 0 and the security configuration outputs are 0.
- R2: One cycle after `trap_valid`, the mode is machine and the previous-privilege field holds the mode that was active in the trap cycle.
- R3: One cycle after `mret_valid` without `trap_valid`, the mode equals the previous-privilege field. When both strobes are high in one cycle, the trap wins.
- R4: During `trap_valid`, `mcause` is 11 for an environment call from machine mode and 8 for one from user mode. Otherwise `mcause` equals `trap_cause`.
- R5: The ISA descriptor (0x301) reads 0x40101104: 32-bit width in bits 31:30, the user bit at position 20, and extension bits 2, 8 and 12. A write to it is illegal and changes nothing.
- R6: Environment configuration (0x30A, 0x31A) and the security configuration high half (0x757) read 0. Writes to them are illegal.
- R7: Cycle (0xC00) and retired-instruction (0xC02) return the low 32 bits of `mcycle` and `minstret`, and 0xC80 and 0xC82 return the high 32 bits. Each value is sampled at acceptance. Writes to any of the four are illegal.
- R8: In user mode, a read of the cycle pair is legal only when counter-enable bit 0 is set, and a read of the retired-instruction pair only when bit 2 is set. Any illegal response carries data 0.
- R9: Counter enable (0x306) keeps only bits 0 and 2, and other bits read 0. Any user-mode access to a CSR whose address bits 9:8 are 2'b11 is illegal and leaves state unchanged.
- R10: Security configuration (0x747) keeps bit 0 (`pmp_lock_mode`), bit 1 (`pmp_deny_unmatched`) and bit 2 (`pmp_rule_unlock`). Other bits read 0.
- R11: The status register (0x300) shows the previous-privilege field at bits 12:11, with other bits 0. Writing 2'b11 there stores machine, and any other value stores user. An unknown address is illegal.
- R12: A legal write returns the value the CSR held before the write. A pending response holds `rsp_valid` and `rsp_rdata` while `rsp_ready` is low, and `req_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap entry strobe |
| trap_ecall | input | 1 | Trap is an environment call |
| trap_cause | input | 5 | Cause code of a non-call trap |
| mret_valid | input | 1 | Return-from-trap strobe |
| mcause | output | 5 | Resolved cause code of the current trap |
| priv_mode | output | 2 | Current mode, 2'b11 machine, 2'b00 user |
| prev_priv | output | 2 | Previous-privilege field |
| req_valid | input | 1 | CSR request valid |
| req_ready | output | 1 | CSR request ready |
| req_addr | input | 12 | CSR address |
| req_we | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data (old value on writes) |
| rsp_illegal | output | 1 | Access was forbidden |
| mcycle | input | 64 | External cycle count |
| minstret | input | 64 | External retired-instruction count |
| pmp_lock_mode | output | 1 | Stored security bit 0 |
| pmp_deny_unmatched | output | 1 | Stored security bit 1 |
| pmp_rule_unlock | output | 1 | Stored security bit 2 |

## Verification
The assertions assume the trap and return strobes last a single cycle. They also assume that the request fields stay stable while `req_valid` is high without acceptance, and that the counter inputs do not change while a request is being accepted. The bench drives every input one time unit after a rising edge and releases each strobe after exactly one cycle. It holds a request until it sees `req_ready`, and it changes `mcycle` and `minstret` only when no request is pending.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_M = 2'b11
  } priv_e;

  localparam logic [11:0] A_STATUS   = 12'h300;
  localparam logic [11:0] A_ISA      = 12'h301;
  localparam logic [11:0] A_CNTEN    = 12'h306;
  localparam logic [11:0] A_ENVCFG   = 12'h30A;
  localparam logic [11:0] A_ENVCFGH  = 12'h31A;
  localparam logic [11:0] A_SECCFG   = 12'h747;
  localparam logic [11:0] A_SECCFGH  = 12'h757;
  localparam logic [11:0] A_CYC      = 12'hC00;
  localparam logic [11:0] A_INST     = 12'hC02;
  localparam logic [11:0] A_CYCH     = 12'hC80;
  localparam logic [11:0] A_INSTH    = 12'hC82;

  localparam int PP_LO = 11;
  localparam int CAUSE_CALL_M = 11;
  localparam int CAUSE_CALL_U = 8;
endpackage

// File: rtl/priv_mode_track.sv
module priv_mode_track
  import priv_csr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_i,
  input  logic  mret_i,
  input  logic  pp_we_i,
  input  priv_e pp_wval_i,
  output priv_e mode_o,
  output priv_e pp_o
);
  priv_e mode_q;
  logic  pp_inv_q;

  assign mode_o = mode_q;
  assign pp_o   = pp_inv_q ? PRIV_U : PRIV_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PRIV_M;
      pp_inv_q <= 1'b0;
    end else if (trap_i) begin
      mode_q   <= PRIV_M;
      pp_inv_q <= (mode_q == PRIV_U);
    end else begin
      if (mret_i) mode_q <= pp_o;
      if (pp_we_i) pp_inv_q <= (pp_wval_i == PRIV_U);
    end
  end

  p_trap_to_m_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> mode_q == PRIV_M);
  p_trap_saves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> pp_o == $past(mode_q));
  p_mret_restore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !trap_i) |=> mode_q == $past(pp_o));
endmodule

// File: rtl/priv_csr_regs.sv
module priv_csr_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnten_we_i,
  input  logic            seccfg_we_i,
  input  logic [2:0]      wbits_i,
  output logic            cy_en_o,
  output logic            ir_en_o,
  output logic [XLEN-1:0] cnten_rd_o,
  output logic [XLEN-1:0] seccfg_rd_o,
  output logic [2:0]      sec_o
);
  logic       cy_q, ir_q;
  logic [2:0] sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q  <= 1'b0;
      ir_q  <= 1'b0;
      sec_q <= '0;
    end else begin
      if (cnten_we_i) begin
        cy_q <= wbits_i[0];
        ir_q <= wbits_i[2];
      end
      if (seccfg_we_i) sec_q <= wbits_i;
    end
  end

  assign cy_en_o     = cy_q;
  assign ir_en_o     = ir_q;
  assign sec_o       = sec_q;
  assign cnten_rd_o  = XLEN'({ir_q, 1'b0, cy_q});
  assign seccfg_rd_o = XLEN'(sec_q);

  p_cnten_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnten_we_i |=> $stable(cnten_rd_o));
  p_sec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !seccfg_we_i |=> $stable(sec_o));
endmodule

// File: rtl/priv_csr_decode.sv
module priv_csr_decode
  import priv_csr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MISA_EXT = 32'h0000_1104
) (
  input  logic [11:0]       addr_i,
  input  logic              we_i,
  input  priv_e             mode_i,
  input  priv_e             pp_i,
  input  logic              cy_en_i,
  input  logic              ir_en_i,
  input  logic [XLEN-1:0]   cnten_rd_i,
  input  logic [XLEN-1:0]   seccfg_rd_i,
  input  logic [2*XLEN-1:0] cyc_i,
  input  logic [2*XLEN-1:0] inst_i,
  output logic              illegal_o,
  output logic [XLEN-1:0]   rdata_o,
  output logic              sel_status_o,
  output logic              sel_cnten_o,
  output logic              sel_seccfg_o
);
  localparam logic [XLEN-1:0] ISA_VAL =
    (XLEN'(1) << (XLEN - 2)) | (XLEN'(1) << 20) | XLEN'(MISA_EXT);

  logic hit, ro, cy_sel, ir_sel, user_blk, cnt_blk;

  always_comb begin
    hit = 1'b1;
    ro  = 1'b0;
    rdata_o = '0;
    cy_sel = 1'b0;
    ir_sel = 1'b0;
    unique case (addr_i)
      A_STATUS:  rdata_o = XLEN'({pp_i, {PP_LO{1'b0}}});
      A_ISA:     begin rdata_o = ISA_VAL; ro = 1'b1; end
      A_CNTEN:   rdata_o = cnten_rd_i;
      A_ENVCFG:  ro = 1'b1;
      A_ENVCFGH: ro = 1'b1;
      A_SECCFG:  rdata_o = seccfg_rd_i;
      A_SECCFGH: ro = 1'b1;
      A_CYC:     begin rdata_o = cyc_i[XLEN-1:0];     ro = 1'b1; cy_sel = 1'b1; end
      A_CYCH:    begin rdata_o = cyc_i[2*XLEN-1:XLEN]; ro = 1'b1; cy_sel = 1'b1; end
      A_INST:    begin rdata_o = inst_i[XLEN-1:0];     ro = 1'b1; ir_sel = 1'b1; end
      A_INSTH:   begin rdata_o = inst_i[2*XLEN-1:XLEN]; ro = 1'b1; ir_sel = 1'b1; end
      default:   hit = 1'b0;
    endcase
    user_blk = (mode_i == PRIV_U) && (addr_i[9:8] == 2'b11);
    cnt_blk  = (mode_i == PRIV_U) && ((cy_sel && !cy_en_i) || (ir_sel && !ir_en_i));
    illegal_o = !hit || user_blk || cnt_blk || (we_i && ro);
  end

  assign sel_status_o = (addr_i == A_STATUS);
  assign sel_cnten_o  = (addr_i == A_CNTEN);
  assign sel_seccfg_o = (addr_i == A_SECCFG);

  always_comb begin
    if (mode_i == PRIV_U && addr_i == A_ISA)
      a_user_isa_r9: assert (illegal_o);
  end
endmodule

// File: rtl/priv_csr_ctrl.sv
module priv_csr_ctrl
  import priv_csr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 5,
  parameter int MISA_EXT = 32'h0000_1104
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_valid,
  input  logic                trap_ecall,
  input  logic [CAUSE_W-1:0]  trap_cause,
  input  logic                mret_valid,
  output logic [CAUSE_W-1:0]  mcause,
  output logic [1:0]          priv_mode,
  output logic [1:0]          prev_priv,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [11:0]         req_addr,
  input  logic                req_we,
  input  logic [XLEN-1:0]     req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [XLEN-1:0]     rsp_rdata,
  output logic                rsp_illegal,
  input  logic [2*XLEN-1:0]   mcycle,
  input  logic [2*XLEN-1:0]   minstret,
  output logic                pmp_lock_mode,
  output logic                pmp_deny_unmatched,
  output logic                pmp_rule_unlock
);
  priv_e mode, pp, pp_wval;
  logic accept, do_wr, dec_ill;
  logic sel_status, sel_cnten, sel_seccfg;
  logic cy_en, ir_en;
  logic [XLEN-1:0] cnten_rd, seccfg_rd, dec_rdata;
  logic [2:0] sec;
  logic rsp_v_q, rsp_ill_q;
  logic [XLEN-1:0] rsp_d_q;
  logic unused_wdata;

  assign unused_wdata = ^{req_wdata[XLEN-1:PP_LO+2], req_wdata[PP_LO-1:3]};

  assign req_ready = !rsp_v_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_wr     = accept && req_we && !dec_ill;
  assign pp_wval   = (req_wdata[PP_LO+1:PP_LO] == 2'b11) ? PRIV_M : PRIV_U;

  priv_mode_track u_track (
    .clk(clk), .rst_n(rst_n),
    .trap_i(trap_valid), .mret_i(mret_valid),
    .pp_we_i(do_wr && sel_status), .pp_wval_i(pp_wval),
    .mode_o(mode), .pp_o(pp)
  );

  priv_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cnten_we_i(do_wr && sel_cnten),
    .seccfg_we_i(do_wr && sel_seccfg),
    .wbits_i(req_wdata[2:0]),
    .cy_en_o(cy_en), .ir_en_o(ir_en),
    .cnten_rd_o(cnten_rd), .seccfg_rd_o(seccfg_rd), .sec_o(sec)
  );

  priv_csr_decode #(.XLEN(XLEN), .MISA_EXT(MISA_EXT)) u_dec (
    .addr_i(req_addr), .we_i(req_we), .mode_i(mode), .pp_i(pp),
    .cy_en_i(cy_en), .ir_en_i(ir_en),
    .cnten_rd_i(cnten_rd), .seccfg_rd_i(seccfg_rd),
    .cyc_i(mcycle), .inst_i(minstret),
    .illegal_o(dec_ill), .rdata_o(dec_rdata),
    .sel_status_o(sel_status), .sel_cnten_o(sel_cnten), .sel_seccfg_o(sel_seccfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q   <= 1'b0;
      rsp_ill_q <= 1'b0;
      rsp_d_q   <= '0;
    end else if (accept) begin
      rsp_v_q   <= 1'b1;
      rsp_ill_q <= dec_ill;
      rsp_d_q   <= dec_ill ? '0 : dec_rdata;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  always_comb begin
    if (trap_ecall)
      mcause = (mode == PRIV_M) ? CAUSE_W'(CAUSE_CALL_M) : CAUSE_W'(CAUSE_CALL_U);
    else
      mcause = trap_cause;
  end

  assign priv_mode          = mode;
  assign prev_priv          = pp;
  assign rsp_valid          = rsp_v_q;
  assign rsp_rdata          = rsp_d_q;
  assign rsp_illegal        = rsp_ill_q;
  assign pmp_lock_mode      = sec[0];
  assign pmp_deny_unmatched = sec[1];
  assign pmp_rule_unlock    = sec[2];

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_illegal)));
  p_ill_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> rsp_rdata == '0);
  p_user_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_we && mode == PRIV_U) |=> ($stable(cnten_rd) && $stable(sec)));
  p_pp_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    prev_priv == 2'b11 || prev_priv == 2'b00);
endmodule

// File: tb/sim_priv_csr_ctrl.sv
module sim_priv_csr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 0, trap_ecall = 0, mret_valid = 0;
  logic [4:0] trap_cause = '0;
  logic [4:0] mcause;
  logic [1:0] priv_mode, prev_priv;
  logic req_valid = 0, req_we = 0, rsp_ready = 1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_illegal;
  logic [31:0] rsp_rdata;
  logic [63:0] mcycle = 64'h1234_5678_9ABC_DEF0;
  logic [63:0] minstret = 64'h0BAD_F00D_0000_0042;
  logic pmp_lock_mode, pmp_deny_unmatched, pmp_rule_unlock;

  int n_chk = 0, n_fail = 0;
  logic [31:0] q_data[$];
  logic        q_ill[$];
  string       q_req[$];

  always #5 clk = ~clk;

  priv_csr_ctrl u0 (.*);

  task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) chk("R12 unexpected response", 1, 0);
      else begin
        string r = q_req.pop_front();
        chk(r, {31'd0, rsp_illegal}, {31'd0, q_ill.pop_front()});
        chk(r, rsp_rdata, q_data.pop_front());
      end
    end
  end

  task automatic issue(input logic [11:0] a, input logic we, input logic [31:0] wd,
                       input logic [31:0] er, input logic ei, input string r);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_we = we; req_wdata = wd;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    q_data.push_back(er); q_ill.push_back(ei); q_req.push_back(r);
    @(posedge clk); #1;
    req_valid = 0; req_we = 0;
  endtask

  task automatic csr(input logic [11:0] a, input logic we, input logic [31:0] wd,
                     input logic [31:0] er, input logic ei, input string r);
    issue(a, we, wd, er, ei, r);
    while (q_data.size() != 0) @(negedge clk);
  endtask

  task automatic strobe(input logic tr, input logic ec, input logic [4:0] cs, input logic mr,
                        input logic [4:0] ecause, input logic [1:0] emode,
                        input logic [1:0] epp, input string r);
    @(posedge clk); #1;
    trap_valid = tr; trap_ecall = ec; trap_cause = cs; mret_valid = mr;
    @(negedge clk);
    if (tr) chk({r, " cause"}, mcause, ecause);
    @(posedge clk); #1;
    trap_valid = 0; trap_ecall = 0; mret_valid = 0;
    @(negedge clk);
    chk({r, " mode"}, priv_mode, emode);
    chk({r, " prev"}, prev_priv, epp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", priv_mode, 2'b11);
    chk("R1 prev", prev_priv, 2'b11);
    chk("R1 sec", {pmp_rule_unlock, pmp_deny_unmatched, pmp_lock_mode}, 0);
    csr(12'h306, 0, 0, 0, 0, "R1 cnten");
    csr(12'h300, 0, 0, 32'h1800, 0, "R11 status reset");
    // R5 ISA descriptor
    csr(12'h301, 0, 0, 32'h4010_1104, 0, "R5 isa read");
    csr(12'h301, 1, 32'hFFFF_FFFF, 0, 1, "R5 isa write");
    csr(12'h301, 0, 0, 32'h4010_1104, 0, "R5 isa unchanged");
    // R6 read-only zero
    csr(12'h30A, 0, 0, 0, 0, "R6 envcfg");
    csr(12'h31A, 1, 32'h1, 0, 1, "R6 envcfgh write");
    csr(12'h757, 0, 0, 0, 0, "R6 seccfgh");
    // R10 security config
    csr(12'h747, 1, 32'hFFFF_FFFF, 0, 0, "R10 sec write");
    csr(12'h747, 0, 0, 32'h7, 0, "R10 sec read");
    @(negedge clk);
    chk("R10 outputs", {pmp_rule_unlock, pmp_deny_unmatched, pmp_lock_mode}, 3'b111);
    csr(12'h747, 1, 32'h2, 32'h7, 0, "R12 old value on write");
    @(negedge clk);
    chk("R10 outputs 2", {pmp_rule_unlock, pmp_deny_unmatched, pmp_lock_mode}, 3'b010);
    // R7 counters from machine mode
    csr(12'hC00, 0, 0, 32'h9ABC_DEF0, 0, "R7 cycle");
    csr(12'hC80, 0, 0, 32'h1234_5678, 0, "R7 cycleh");
    csr(12'hC02, 0, 0, 32'h0000_0042, 0, "R7 instret");
    csr(12'hC82, 0, 0, 32'h0BAD_F00D, 0, "R7 instreth");
    csr(12'hC00, 1, 32'h5, 0, 1, "R7 cycle write");
    csr(12'h7C0, 0, 0, 0, 1, "R11 unknown addr");
    // R11 status write then return to user
    csr(12'h300, 1, 32'h0000_1000, 32'h1800, 0, "R11 status write");
    csr(12'h300, 0, 0, 32'h0, 0, "R11 status reads user");
    strobe(0, 0, 0, 1, 0, 2'b00, 2'b00, "R3 mret to user");
    // R8/R9 user restrictions
    csr(12'hC00, 0, 0, 0, 1, "R8 cycle blocked");
    csr(12'h301, 0, 0, 0, 1, "R9 user isa");
    csr(12'h306, 1, 32'h5, 0, 1, "R9 user cnten write");
    csr(12'h747, 1, 32'h0, 0, 1, "R9 user sec write");
    @(negedge clk);
    chk("R9 sec unchanged", {pmp_rule_unlock, pmp_deny_unmatched, pmp_lock_mode}, 3'b010);
    strobe(1, 1, 5'd3, 0, 5'd8, 2'b11, 2'b00, "R4 ecall user");
    csr(12'h306, 0, 0, 0, 0, "R9 cnten unchanged");
    csr(12'h306, 1, 32'hFFFF_FFFF, 0, 0, "R9 cnten write");
    csr(12'h306, 0, 0, 32'h5, 0, "R9 cnten keeps bits");
    csr(12'h306, 1, 32'h1, 32'h5, 0, "R9 cnten cycle only");
    strobe(0, 0, 0, 1, 0, 2'b00, 2'b00, "R3 mret user again");
    mcycle = 64'hAAAA_0001_5555_0002;
    csr(12'hC00, 0, 0, 32'h5555_0002, 0, "R8 cycle allowed");
    csr(12'hC80, 0, 0, 32'hAAAA_0001, 0, "R8 cycleh allowed");
    csr(12'hC02, 0, 0, 0, 1, "R8 instret blocked");
    strobe(1, 1, 0, 0, 5'd8, 2'b11, 2'b00, "R4 ecall user 2");
    strobe(1, 1, 0, 0, 5'd11, 2'b11, 2'b11, "R4 ecall machine");
    strobe(1, 0, 5'd5, 0, 5'd5, 2'b11, 2'b11, "R4 passthrough");
    // R3 trap wins over mret
    csr(12'h300, 1, 32'h0, 32'h1800, 0, "R11 status to user");
    strobe(0, 0, 0, 1, 0, 2'b00, 2'b00, "R3 mret");
    strobe(1, 0, 5'd2, 1, 5'd2, 2'b11, 2'b00, "R3 trap priority");
    // R12 back-pressure
    @(posedge clk); #1 rsp_ready = 0;
    issue(12'h747, 0, 0, 32'h2, 0, "R12 held response");
    @(negedge clk);
    chk("R12 valid", rsp_valid, 1);
    repeat (3) @(negedge clk);
    chk("R12 still valid", rsp_valid, 1);
    chk("R12 data stable", rsp_rdata, 32'h2);
    chk("R12 ready low", req_ready, 0);
    @(posedge clk); #1 rsp_ready = 1;
    while (q_data.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R12 drained", rsp_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule